// File: doc/BRIEF.md
# Dual Trigger-Output Selector

This block sits beside the counter of an advanced timer and chooses what the timer sends to other blocks on its two trigger lines. Each line has its own mode code held in a 32-bit control word. A code can select a counter event, the counter-enable level, the channel-1 compare match or one of six output-compare reference levels. On the second line, a code can also select a single-cycle pulse made from edges of those references.

The primary code (3 bits) drives `trgo` and the secondary code (4 bits) drives `trgo2`. The secondary line has extra modes. Two of them pulse on both edges of one reference. Four of them merge a rising edge of reference 4 or 5 with a rising or falling edge of reference 6. This lets a centre-aligned counter mark two separate instants in one period on a single line.

A parameter removes the secondary selector. When it is removed, its code bits cannot be written and always read as zero. Software writes ones to those bits and reads them back to find out whether the line exists.

Top module: `trig_out_sel`

## Requirements
- R1: The control word keeps the primary code in bits 6:4 and the secondary code in bits 23:20. A write (`ctl_we` high at a clock edge) loads both fields from `ctl_wdata`. Every other bit of `ctl_rdata` reads zero, and the word resets to zero.
- R2: Both outputs are registered. The output seen after clock edge k is computed from the inputs present at edge k and from the code stored before edge k. A new code therefore governs the output from the edge after the write.
- R3: Code 0 gives a one-cycle high when the counter-reset event or the software update strobe is present. Code 2 does the same for the counter-update event or the software update strobe.
- R4: Code 1 follows the counter-enable level. Code 3 follows the channel-1 compare-match event.
- R5: Codes 4, 5, 6 and 7 follow references 1 to 4, which are `oc_ref` bits 0 to 3. On the secondary line, codes 8 and 9 follow references 5 and 6, which are `oc_ref` bits 4 and 5.
- R6: Secondary code 10 is high for one cycle on every change of reference 4. Code 11 does the same for reference 6. A change means the level at this edge differs from the level at the previous edge. The stored previous levels reset to zero.
- R7: Secondary codes 12, 13, 14 and 15 are high when one of two edges occurs:
  - code 12: reference 4 rises or reference 6 rises;
  - code 13: reference 4 rises or reference 6 falls;
  - code 14: reference 5 rises or reference 6 rises;
  - code 15: reference 5 rises or reference 6 falls.
  When both edges occur at the same edge, the output is high for a single cycle.
- R8: Secondary codes 0 to 7 behave exactly like the same primary codes.
- R9: With `HAS_TRGO2` = 0, writes to bits 23:20 have no effect, those bits read zero and `trgo2` stays low. The primary line is unchanged.
- R10: While reset is applied, `trgo`, `trgo2` and `ctl_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read value |
| cnt_reset_evt | input | 1 | Counter reset event, one cycle |
| cnt_enable | input | 1 | Counter enable level |
| cnt_update_evt | input | 1 | Counter update event, one cycle |
| sw_update | input | 1 | Software update-generation strobe |
| cc1_match | input | 1 | Channel-1 compare match event |
| oc_ref | input | 6 | Output-compare reference levels 1 to 6 (bit 0 is reference 1) |
| trgo | output | 1 | Primary trigger output |
| trgo2 | output | 1 | Secondary trigger output |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around the sampling edge. They also assume that the event inputs are already single-cycle strobes from the counter logic, so a level held on them simply passes through. The bench drives all inputs just after the falling edge. It releases reset away from any rising edge and waits out the internal reset synchronizer before it issues the first write. The reference levels toggle sparsely and at random, and a directed sequence also raises references 4 and 6 together.

// File: rtl/trgsel_pkg.sv
package trgsel_pkg;
  localparam int CTL_W   = 32;
  localparam int PRI_LSB = 4;
  localparam int PRI_W   = 3;
  localparam int SEC_LSB = 20;
  localparam int SEC_W   = 4;
  localparam int NREF    = 6;

  typedef enum logic [SEC_W-1:0] {
    SEL_RESET   = 4'd0,
    SEL_ENABLE  = 4'd1,
    SEL_UPDATE  = 4'd2,
    SEL_CMP     = 4'd3,
    SEL_REF1    = 4'd4,
    SEL_REF2    = 4'd5,
    SEL_REF3    = 4'd6,
    SEL_REF4    = 4'd7,
    SEL_REF5    = 4'd8,
    SEL_REF6    = 4'd9,
    SEL_BOTH4   = 4'd10,
    SEL_BOTH6   = 4'd11,
    SEL_R4_R6   = 4'd12,
    SEL_R4_F6   = 4'd13,
    SEL_R5_R6   = 4'd14,
    SEL_R5_F6   = 4'd15
  } sel_e;

  typedef struct packed {
    logic rst_pulse;
    logic en_lvl;
    logic upd_pulse;
    logic cmp_pulse;
  } evt_t;
endpackage

// File: rtl/trgsel_reset_sync.sv
module trgsel_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/trgsel_ctl_reg.sv
module trgsel_ctl_reg
  import trgsel_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] rdata,
  output logic [PRI_W-1:0] pri_mode,
  output logic [SEC_W-1:0] sec_mode
);
  localparam logic [CTL_W-1:0] PRI_MASK  = CTL_W'(((1 << PRI_W) - 1) << PRI_LSB);
  localparam logic [CTL_W-1:0] SEC_MASK  = CTL_W'(((1 << SEC_W) - 1) << SEC_LSB);
  localparam logic [CTL_W-1:0] USED_MASK = HAS_SEC ? (PRI_MASK | SEC_MASK) : PRI_MASK;

  logic [PRI_W-1:0] pri_q, pri_d;

  always_comb begin
    pri_d = pri_q;
    if (we) pri_d = wdata[PRI_LSB +: PRI_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pri_q <= '0;
    else        pri_q <= pri_d;
  end

  generate
    if (HAS_SEC) begin : g_sec
      logic [SEC_W-1:0] sec_q, sec_d;

      always_comb begin
        sec_d = sec_q;
        if (we) sec_d = wdata[SEC_LSB +: SEC_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sec_q <= '0;
        else        sec_q <= sec_d;
      end

      assign sec_mode = sec_q;
    end else begin : g_no_sec
      assign sec_mode = '0;
    end
  endgenerate

  logic unused_wbits;
  assign unused_wbits = ^(wdata & ~USED_MASK);

  always_comb begin
    rdata = '0;
    rdata[PRI_LSB +: PRI_W] = pri_q;
    rdata[SEC_LSB +: SEC_W] = sec_mode;
  end

  assign pri_mode = pri_q;
endmodule

// File: rtl/trgsel_edge_det.sv
module trgsel_edge_det #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q, prev_d;

  always_comb begin
    prev_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
  end
endmodule

// File: rtl/trgsel_mux.sv
module trgsel_mux
  import trgsel_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic [MODE_W-1:0] mode,
  input  evt_t              evt,
  input  logic [NREF-1:0]   lvl,
  input  logic [NREF-1:0]   rise,
  input  logic [NREF-1:0]   fall,
  output logic              y
);
  sel_e sel;

  always_comb begin
    sel = sel_e'(SEC_W'(mode));
    y   = 1'b0;
    unique case (sel)
      SEL_RESET:  y = evt.rst_pulse;
      SEL_ENABLE: y = evt.en_lvl;
      SEL_UPDATE: y = evt.upd_pulse;
      SEL_CMP:    y = evt.cmp_pulse;
      SEL_REF1:   y = lvl[0];
      SEL_REF2:   y = lvl[1];
      SEL_REF3:   y = lvl[2];
      SEL_REF4:   y = lvl[3];
      SEL_REF5:   y = lvl[4];
      SEL_REF6:   y = lvl[5];
      SEL_BOTH4:  y = rise[3] | fall[3];
      SEL_BOTH6:  y = rise[5] | fall[5];
      SEL_R4_R6:  y = rise[3] | rise[5];
      SEL_R4_F6:  y = rise[3] | fall[5];
      SEL_R5_R6:  y = rise[4] | rise[5];
      SEL_R5_F6:  y = rise[4] | fall[5];
      default:    y = 1'b0;
    endcase
  end
endmodule

// File: rtl/trig_out_sel.sv
module trig_out_sel
  import trgsel_pkg::*;
#(
  parameter bit HAS_TRGO2 = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             cnt_reset_evt,
  input  logic             cnt_enable,
  input  logic             cnt_update_evt,
  input  logic             sw_update,
  input  logic             cc1_match,
  input  logic [NREF-1:0]  oc_ref,
  output logic             trgo,
  output logic             trgo2
);
  logic             rst_q;
  logic [PRI_W-1:0] pri_mode;
  logic [SEC_W-1:0] sec_mode;
  logic [NREF-1:0]  ref_rise, ref_fall;
  evt_t             evt;
  logic             pri_y, sec_y;
  logic             trgo_q, trgo_d, trgo2_q, trgo2_d;

  trgsel_reset_sync #(.STAGES(2)) u_rsync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_q)
  );

  trgsel_ctl_reg #(.HAS_SEC(HAS_TRGO2)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_q),
    .we       (ctl_we),
    .wdata    (ctl_wdata),
    .rdata    (ctl_rdata),
    .pri_mode (pri_mode),
    .sec_mode (sec_mode)
  );

  trgsel_edge_det #(.N(NREF)) u_edge (
    .clk   (clk),
    .rst_n (rst_q),
    .lvl   (oc_ref),
    .rise  (ref_rise),
    .fall  (ref_fall)
  );

  always_comb begin
    evt.rst_pulse = cnt_reset_evt | sw_update;
    evt.en_lvl    = cnt_enable;
    evt.upd_pulse = cnt_update_evt | sw_update;
    evt.cmp_pulse = cc1_match;
  end

  trgsel_mux #(.MODE_W(PRI_W)) u_pri_mux (
    .mode (pri_mode),
    .evt  (evt),
    .lvl  (oc_ref),
    .rise (ref_rise),
    .fall (ref_fall),
    .y    (pri_y)
  );

  generate
    if (HAS_TRGO2) begin : g_sec_mux
      trgsel_mux #(.MODE_W(SEC_W)) u_sec_mux (
        .mode (sec_mode),
        .evt  (evt),
        .lvl  (oc_ref),
        .rise (ref_rise),
        .fall (ref_fall),
        .y    (sec_y)
      );
    end else begin : g_sec_off
      logic unused_sec;
      assign unused_sec = ^sec_mode;
      assign sec_y = 1'b0;
    end
  endgenerate

  always_comb begin
    trgo_d  = pri_y;
    trgo2_d = sec_y;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      trgo_q  <= 1'b0;
      trgo2_q <= 1'b0;
    end else begin
      trgo_q  <= trgo_d;
      trgo2_q <= trgo2_d;
    end
  end

  assign trgo  = trgo_q;
  assign trgo2 = trgo2_q;
endmodule

// File: rtl/trig_out_sel_chk.sv
module trig_out_sel_chk #(
  parameter bit HAS_TRGO2 = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic [2:0]  wr_pri,
  input logic [3:0]  wr_sec,
  input logic [31:0] ctl_rdata,
  input logic        cnt_enable,
  input logic        oc6,
  input logic        trgo,
  input logic        trgo2
);
  localparam logic [31:0] LIVE_MASK = HAS_TRGO2 ? 32'h00F0_0070 : 32'h0000_0070;

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata & ~LIVE_MASK) == 32'h0);

  // R1
  pri_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_rdata[6:4] == $past(wr_pri));

  // R1
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_rdata));

  // R4
  enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[6:4] == 3'd1) |=> trgo == $past(cnt_enable));

  generate
    if (HAS_TRGO2) begin : g_has
      // R1
      sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> ctl_rdata[23:20] == $past(wr_sec));

      // R5
      ref6_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[23:20] == 4'd9) |=> trgo2 == $past(oc6));
    end else begin : g_absent
      logic unused_in;
      assign unused_in = ^{wr_sec, oc6};

      // R9
      sec_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trgo2 && ctl_rdata[23:20] == 4'd0);
    end
  endgenerate
endmodule

bind trig_out_sel trig_out_sel_chk #(.HAS_TRGO2(HAS_TRGO2)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .ctl_we     (ctl_we),
  .wr_pri     (ctl_wdata[6:4]),
  .wr_sec     (ctl_wdata[23:20]),
  .ctl_rdata  (ctl_rdata),
  .cnt_enable (cnt_enable),
  .oc6        (oc_ref[5]),
  .trgo       (trgo),
  .trgo2      (trgo2)
);

// File: tb/test_trig_out_sel.sv
module test_trig_out_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [31:0] ctl_wdata;
  logic        cnt_reset_evt, cnt_enable, cnt_update_evt, sw_update, cc1_match;
  logic [5:0]  oc_ref;
  logic [31:0] rd_f, rd_l;
  logic        trgo_f, trgo2_f, trgo_l, trgo2_l;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  trig_out_sel #(.HAS_TRGO2(1'b1)) i_trig_out_sel (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(rd_f), .cnt_reset_evt(cnt_reset_evt), .cnt_enable(cnt_enable),
    .cnt_update_evt(cnt_update_evt), .sw_update(sw_update), .cc1_match(cc1_match),
    .oc_ref(oc_ref), .trgo(trgo_f), .trgo2(trgo2_f)
  );

  trig_out_sel #(.HAS_TRGO2(1'b0)) i_trig_out_sel_lite (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(rd_l), .cnt_reset_evt(cnt_reset_evt), .cnt_enable(cnt_enable),
    .cnt_update_evt(cnt_update_evt), .sw_update(sw_update), .cc1_match(cc1_match),
    .oc_ref(oc_ref), .trgo(trgo_l), .trgo2(trgo2_l)
  );

  // Behavioural model state
  int         m_pri = 0;
  int         m_sec = 0;
  bit [5:0]   m_prev = '0;
  bit [31:0]  m_rd = '0;
  bit         m_wrote = 0;
  bit         exp_p, exp_s;
  string      tag_p, tag_s;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model(input int m, input bit rs, input bit en, input bit up,
                               input bit sw, input bit cc, input bit [5:0] oc,
                               input bit [5:0] pv);
    bit r4, f4, r5, r6, f6;
    r4 = oc[3] & !pv[3]; f4 = !oc[3] & pv[3];
    r5 = oc[4] & !pv[4];
    r6 = oc[5] & !pv[5]; f6 = !oc[5] & pv[5];
    case (m)
      0:  return rs | sw;
      1:  return en;
      2:  return up | sw;
      3:  return cc;
      4:  return oc[0];
      5:  return oc[1];
      6:  return oc[2];
      7:  return oc[3];
      8:  return oc[4];
      9:  return oc[5];
      10: return r4 | f4;
      11: return r6 | f6;
      12: return r4 | r6;
      13: return r4 | f6;
      14: return r5 | r6;
      default: return r5 | f6;
    endcase
  endfunction

  function automatic string tag_of(input int m, input bit sec);
    if (sec && m < 8) return "R8";
    if (m == 0 || m == 2) return "R3";
    if (m == 1 || m == 3) return "R4";
    if (m <= 9) return "R5";
    if (m <= 11) return "R6";
    return "R7";
  endfunction

  // One clock: drive now (after a falling edge), model at the rising edge, compare at the next falling edge.
  task automatic cycle(input bit we, input bit [31:0] wd, input bit rs, input bit en,
                       input bit up, input bit sw, input bit cc, input bit [5:0] oc);
    ctl_we = we; ctl_wdata = wd;
    cnt_reset_evt = rs; cnt_enable = en; cnt_update_evt = up; sw_update = sw;
    cc1_match = cc; oc_ref = oc;
    @(posedge clk);
    exp_p = model(m_pri, rs, en, up, sw, cc, oc, m_prev);
    exp_s = model(m_sec, rs, en, up, sw, cc, oc, m_prev);
    tag_p = m_wrote ? "R2" : tag_of(m_pri, 1'b0);
    tag_s = m_wrote ? "R2" : tag_of(m_sec, 1'b1);
    m_prev = oc;
    m_wrote = we;
    if (we) begin
      m_pri = int'(wd[6:4]);
      m_sec = int'(wd[23:20]);
      m_rd  = wd & 32'h00F0_0070;
    end
    @(negedge clk);
    check(tag_p, 32'(trgo_f), 32'(exp_p));
    check(tag_s, 32'(trgo2_f), 32'(exp_s));
    check("R1", rd_f, m_rd);
    check("R9", 32'(trgo_l), 32'(exp_p));
    check("R9", 32'(trgo2_l), 32'h0);
    check("R9", rd_l, m_rd & 32'h0000_0070);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    bit [5:0]  oc_cur;
    bit [31:0] wd;
    rst_n = 1'b0;
    ctl_we = 1'b1; ctl_wdata = 32'hFFFF_FFFF;
    cnt_reset_evt = 1'b1; cnt_enable = 1'b1; cnt_update_evt = 1'b1;
    sw_update = 1'b1; cc1_match = 1'b1; oc_ref = 6'h3F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: everything idle while reset is held, whatever the inputs do
    check("R10", 32'(trgo_f), 32'h0);
    check("R10", 32'(trgo2_f), 32'h0);
    check("R10", rd_f, 32'h0);
    check("R10", rd_l, 32'h0);
    ctl_we = 1'b0; ctl_wdata = '0;
    cnt_reset_evt = 1'b0; cnt_enable = 1'b0; cnt_update_evt = 1'b0;
    sw_update = 1'b0; cc1_match = 1'b0; oc_ref = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R9: all-ones write reveals which fields exist
    cycle(1'b1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 6'h0);
    cycle(1'b0, 32'h0, 0, 0, 0, 0, 0, 6'h0);
    check("R1", rd_f, 32'h00F0_0070);
    check("R9", rd_l, 32'h0000_0070);

    oc_cur = '0;
    for (int m = 0; m < 16; m++) begin
      wd = $urandom;
      wd[6:4]   = 3'(m % 8);
      wd[23:20] = 4'(m);
      cycle(1'b1, wd, 0, 0, 0, 0, 0, oc_cur);
      for (int k = 0; k < 48; k++) begin
        oc_cur = oc_cur ^ 6'($urandom & $urandom);
        cycle(1'b0, $urandom, ($urandom % 5) == 0, 1'($urandom), ($urandom % 4) == 0,
              ($urandom % 7) == 0, ($urandom % 3) == 0, oc_cur);
      end
    end

    // R7: coincident edges on references 4 and 6 give one single-cycle pulse
    cycle(1'b1, 32'h00C0_0070, 0, 0, 0, 0, 0, 6'h00);
    cycle(1'b0, 32'h0, 0, 0, 0, 0, 0, 6'h00);
    cycle(1'b0, 32'h0, 0, 0, 0, 0, 0, 6'h28);
    check("R7", 32'(trgo2_f), 32'h1);
    cycle(1'b0, 32'h0, 0, 0, 0, 0, 0, 6'h28);
    check("R7", 32'(trgo2_f), 32'h0);
    // R7: code 13, reference 4 rises while reference 6 falls at the same edge
    cycle(1'b1, 32'h00D0_0000, 0, 0, 0, 0, 0, 6'h20);
    cycle(1'b0, 32'h0, 0, 0, 0, 0, 0, 6'h20);
    cycle(1'b0, 32'h0, 0, 0, 0, 0, 0, 6'h08);
    check("R7", 32'(trgo2_f), 32'h1);
    cycle(1'b0, 32'h0, 0, 0, 0, 0, 0, 6'h08);
    check("R7", 32'(trgo2_f), 32'h0);

    // R3: software strobe alone drives update mode on both lines
    cycle(1'b1, 32'h0020_0020, 0, 0, 0, 0, 0, 6'h0);
    cycle(1'b0, 32'h0, 0, 0, 0, 1, 0, 6'h0);
    check("R3", 32'(trgo_f), 32'h1);
    check("R3", 32'(trgo2_f), 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule